// File: doc/BRIEF.md
# Tagged Operand Instruction Fetch Unit

This block feeds a structure coprocessor with instructions from two streams. In accelerator mode a host pushes complete commands through a command queue, and each one is sent to execution the cycle after it is presented. In autonomous mode the block runs its own program counter over a local command memory. Each local instruction carries an opcode, three operand fields and one validity tag per operand. A local instruction whose tags are not all valid is parked in a hold register until the missing operands arrive.

Missing operands come from a host data queue. Every data word carries the number of the operand slot it fills, so words may come in any order. The block also resolves a local conditional jump. The jump's target and direction may each be supplied late through their tags. A jump is consumed inside the block and is never presented at the issue port.

The local command memory sits outside the block and is read asynchronously: the block drives `cmd_addr` and samples `cmd_data` in the same cycle.

Top module: `tag_fetch_unit`

## Requirements
- R1: While reset is asserted and right after it, `iss_valid` and `tag_err` are 0 and `cmd_addr` is 0.
- R2: A host command presented with `hq_valid` is issued in the next cycle with `iss_src`=1, and its opcode and operands are unchanged. The host command word is {opcode[3:0], operand2, operand1, operand0}, with operand0 in the lowest bits, and it carries no tags.
- R3: In any cycle with `hq_valid` high, no local instruction is issued, even when one is ready.
- R4: When `local_en` is high and the hold register is empty, the word at `cmd_addr` is loaded. The local word is {opcode[3:0], tags[2:0], operand2, operand1, operand0}, and tag bit k=1 means operand k is valid. A ready non-jump instruction is issued with `iss_src`=0, and the program counter then advances by 1.
- R5: A held non-jump instruction with any tag at 0 is not issued and `cmd_addr` does not move. A data word with `hd_tag`=k (0..2) writes operand k and sets its tag, and words may come in any order. Once all three tags are set, the instruction is issued carrying the supplied values.
- R6: A data word is dropped and `tag_err` is set to 1 when any of these holds: `hd_tag` is 3, no instruction is held, or the addressed slot is already valid. The dropped word has no effect on any operand. `tag_err` stays at 1 until reset.
- R7: Opcode 4'hF is a jump. Operand0 bits [7:0] hold the target and operand1 bit 0 holds the direction. Tag0 marks the target valid and tag1 marks the direction valid. Direction 1 loads the program counter with the target, and direction 0 advances it by 1. A jump is never presented at the issue port.
- R8: A jump waits until both tag0 and tag1 are valid, with the two values supplied in either order. Tag2 of a jump is ignored.
- R9: A host command whose opcode is 4'hF is discarded: nothing is issued and the program counter is unchanged.
- R10: A local instruction stalled for operands does not block host commands.
- R11: The 8-bit program counter wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_en | input | 1 | Allows fetching from the local command memory |
| cmd_addr | output | 8 | Program counter, address into the local command memory |
| cmd_data | input | 55 | Local instruction word at `cmd_addr` |
| hq_valid | input | 1 | Host command present (consumed in the same cycle) |
| hq_cmd | input | 52 | Host command word |
| hd_valid | input | 1 | Host data word present |
| hd_tag | input | 2 | Operand slot number of the data word |
| hd_data | input | 16 | Operand value |
| iss_valid | output | 1 | Instruction issued this cycle |
| iss_src | output | 1 | 1 = host command, 0 = local instruction |
| iss_op | output | 4 | Issued opcode |
| iss_opnd | output | 48 | Issued operands {operand2, operand1, operand0} |
| tag_err | output | 1 | Sticky flag for a dropped data word |

## Verification
The bench first sends host-only traffic with mixed tag bits and a host jump, which separates "tags ignored for host" from "host jump dropped". It then sends a host burst while a ready local instruction waits, which shows host priority apart from plain ordering. A local program then covers four things: an instruction with one pending operand, taken and fall-through jumps, a jump whose direction arrives before its target, and an instruction whose two pending operands arrive in reverse slot order. Finally, a data word aimed at an already valid jump target must leave the jump landing on the original address, and a jump to 255 must wrap to 0.

// File: rtl/tag_fetch_unit.sv
module tag_fetch_unit #(
  parameter int W   = 16,
  parameter int PCW = 8,
  parameter int OPW = 4,
  parameter logic [OPW-1:0] JMP = '1,
  localparam int OW = 3*W,
  localparam int IW = OPW + 3 + OW,
  localparam int HW = OPW + OW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           local_en,
  output logic [PCW-1:0] cmd_addr,
  input  logic [IW-1:0]  cmd_data,
  input  logic           hq_valid,
  input  logic [HW-1:0]  hq_cmd,
  input  logic           hd_valid,
  input  logic [1:0]     hd_tag,
  input  logic [W-1:0]   hd_data,
  output logic           iss_valid,
  output logic           iss_src,
  output logic [OPW-1:0] iss_op,
  output logic [OW-1:0]  iss_opnd,
  output logic           tag_err
);

  logic [PCW-1:0] pc;
  logic           held;
  logic [OPW-1:0] h_op;
  logic [2:0]     h_tag;
  logic [W-1:0]   h_opnd [0:2];

  wire is_jmp   = (h_op == JMP);
  wire ready    = held && (is_jmp ? &h_tag[1:0] : &h_tag);
  wire stalled  = held && !ready;
  wire go_local = ready && !hq_valid;
  wire host_jmp = (hq_cmd[HW-1 -: OPW] == JMP);
  wire hit      = hd_valid && held && (hd_tag != 2'd3) && !h_tag[hd_tag];
  wire take     = h_opnd[1][0];

  assign cmd_addr = pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= '0;
      held      <= 1'b0;
      h_op      <= '0;
      h_tag     <= '0;
      for (int i = 0; i < 3; i++) h_opnd[i] <= '0;
      iss_valid <= 1'b0;
      iss_src   <= 1'b0;
      iss_op    <= '0;
      iss_opnd  <= '0;
      tag_err   <= 1'b0;
    end else begin
      iss_valid <= 1'b0;
      if (hd_valid && !hit) tag_err <= 1'b1;
      if (hit) begin
        h_opnd[hd_tag] <= hd_data;
        h_tag[hd_tag]  <= 1'b1;
      end
      if (hq_valid) begin
        if (!host_jmp) begin
          iss_valid <= 1'b1;
          iss_src   <= 1'b1;
          iss_op    <= hq_cmd[HW-1 -: OPW];
          iss_opnd  <= hq_cmd[OW-1:0];
        end
      end else if (go_local) begin
        held <= 1'b0;
        if (is_jmp) begin
          pc <= take ? h_opnd[0][PCW-1:0] : pc + 1'b1;
        end else begin
          iss_valid <= 1'b1;
          iss_src   <= 1'b0;
          iss_op    <= h_op;
          iss_opnd  <= {h_opnd[2], h_opnd[1], h_opnd[0]};
          pc        <= pc + 1'b1;
        end
      end
      if (!held && local_en) begin
        held      <= 1'b1;
        h_op      <= cmd_data[IW-1 -: OPW];
        h_tag     <= cmd_data[OW +: 3];
        h_opnd[0] <= cmd_data[0 +: W];
        h_opnd[1] <= cmd_data[W +: W];
        h_opnd[2] <= cmd_data[2*W +: W];
      end
    end
  end

endmodule

// File: rtl/tag_fetch_unit_chk.sv
module tag_fetch_unit_chk #(
  parameter int PCW = 8,
  parameter int OPW = 4,
  parameter logic [OPW-1:0] JMP = '1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hq_valid,
  input logic [OPW-1:0] hq_op,
  input logic           hd_valid,
  input logic [1:0]     hd_tag,
  input logic           iss_valid,
  input logic           iss_src,
  input logic           tag_err,
  input logic           stalled,
  input logic [PCW-1:0] cmd_addr
);

  p_host_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hq_valid && hq_op != JMP |=> iss_valid && iss_src);

  p_host_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hq_valid |=> !(iss_valid && !iss_src));

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> !(iss_valid && !iss_src));

  p_stall_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> $stable(cmd_addr));

  p_bad_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hd_valid && hd_tag == 2'd3 |=> tag_err);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tag_err |=> tag_err);

  p_host_jmp_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hq_valid && hq_op == JMP |=> !iss_valid);

endmodule

bind tag_fetch_unit tag_fetch_unit_chk #(.PCW(PCW), .OPW(OPW), .JMP(JMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .hq_valid(hq_valid), .hq_op(hq_cmd[HW-1 -: OPW]),
  .hd_valid(hd_valid), .hd_tag(hd_tag), .iss_valid(iss_valid), .iss_src(iss_src),
  .tag_err(tag_err), .stalled(stalled), .cmd_addr(cmd_addr)
);

// File: tb/tag_fetch_unit_test.sv
module tag_fetch_unit_test;
  localparam int CLK_NS = 10;
  localparam int W = 16;
  localparam int IW = 4 + 3 + 3*W;
  localparam int HW = 4 + 3*W;

  logic clk = 0;
  logic rst_n = 0;
  logic local_en = 0;
  logic [7:0] cmd_addr;
  logic [IW-1:0] cmd_data;
  logic hq_valid = 0;
  logic [HW-1:0] hq_cmd = '0;
  logic hd_valid = 0;
  logic [1:0] hd_tag = 0;
  logic [W-1:0] hd_data = 0;
  logic iss_valid, iss_src, tag_err;
  logic [3:0] iss_op;
  logic [3*W-1:0] iss_opnd;

  logic [IW-1:0] mem [0:255];
  assign cmd_data = mem[cmd_addr];

  always #(CLK_NS/2) clk = ~clk;

  tag_fetch_unit uut (
    .clk(clk), .rst_n(rst_n), .local_en(local_en), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .hq_valid(hq_valid), .hq_cmd(hq_cmd), .hd_valid(hd_valid), .hd_tag(hd_tag), .hd_data(hd_data),
    .iss_valid(iss_valid), .iss_src(iss_src), .iss_op(iss_op), .iss_opnd(iss_opnd), .tag_err(tag_err)
  );

  logic [HW-1:0] host_q[$];
  logic [HW-1:0] local_q[$];
  int checks = 0, errors = 0, m_checks = 0, m_errors = 0;
  int n_host = 0, n_local = 0;

  function automatic logic [IW-1:0] mk(input logic [3:0] op, input logic [2:0] tg,
                                       input logic [W-1:0] a2, a1, a0);
    return {op, tg, a2, a1, a0};
  endfunction

  function automatic logic [HW-1:0] hc(input logic [3:0] op, input logic [W-1:0] a2, a1, a0);
    return {op, a2, a1, a0};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && iss_valid) begin
      m_checks++;
      if (iss_src) begin
        n_host++;
        if (host_q.size() == 0) begin
          m_errors++;
          $display("FAIL R2 unexpected host issue actual=%0h expected=none", {iss_op, iss_opnd});
        end else begin
          logic [HW-1:0] e;
          e = host_q.pop_front();
          if ({iss_op, iss_opnd} !== e) begin
            m_errors++;
            $display("FAIL R2 host issue actual=%0h expected=%0h", {iss_op, iss_opnd}, e);
          end
        end
      end else begin
        n_local++;
        if (local_q.size() == 0) begin
          m_errors++;
          $display("FAIL R4 unexpected local issue actual=%0h expected=none", {iss_op, iss_opnd});
        end else begin
          logic [HW-1:0] e;
          e = local_q.pop_front();
          if ({iss_op, iss_opnd} !== e) begin
            m_errors++;
            $display("FAIL R5 local issue actual=%0h expected=%0h", {iss_op, iss_opnd}, e);
          end
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_host(input logic [HW-1:0] c, input logic expect_issue);
    @(negedge clk);
    hq_valid = 1; hq_cmd = c;
    if (expect_issue) host_q.push_back(c);
    @(negedge clk);
    hq_valid = 0;
  endtask

  task automatic send_data(input logic [1:0] t, input logic [W-1:0] v);
    @(negedge clk);
    hd_valid = 1; hd_tag = t; hd_data = v;
    @(negedge clk);
    hd_valid = 0;
  endtask

  task automatic wait_addr(input logic [7:0] a, input string req);
    bit found = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (cmd_addr == a) begin found = 1; break; end
    end
    chk(found, req, cmd_addr, a);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors + m_errors + 1, checks + m_checks + 1);
    $finish;
  end

  initial begin
    int hb;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[0]  = mk(4'h1, 3'b111, 16'h0a02, 16'h0a01, 16'h0a00);
    mem[1]  = mk(4'h2, 3'b111, 16'h0b02, 16'h0b01, 16'h0b00);
    mem[2]  = mk(4'hF, 3'b111, 16'h0, 16'h1, 16'd10);
    mem[10] = mk(4'h3, 3'b101, 16'h003c, 16'hdead, 16'h003a);
    mem[11] = mk(4'hF, 3'b111, 16'h0, 16'h0, 16'd50);
    mem[50] = mk(4'hF, 3'b111, 16'h0, 16'h1, 16'd50);
    mem[12] = mk(4'h4, 3'b111, 16'h0c02, 16'h0c01, 16'h0c00);
    mem[13] = mk(4'hF, 3'b100, 16'h0, 16'h0, 16'h0);
    mem[30] = mk(4'h5, 3'b001, 16'hffff, 16'hffff, 16'h05a0);
    mem[31] = mk(4'h6, 3'b111, 16'h0e02, 16'h0e01, 16'h0e00);
    mem[32] = mk(4'hF, 3'b111, 16'h0, 16'h1, 16'd32);
    local_q.push_back(hc(4'h1, 16'h0a02, 16'h0a01, 16'h0a00));
    local_q.push_back(hc(4'h2, 16'h0b02, 16'h0b01, 16'h0b00));
    local_q.push_back(hc(4'h3, 16'h003c, 16'h1234, 16'h003a));
    local_q.push_back(hc(4'h4, 16'h0c02, 16'h0c01, 16'h0c00));
    local_q.push_back(hc(4'h5, 16'h05b2, 16'h05b1, 16'h05a0));
    local_q.push_back(hc(4'h6, 16'h0e02, 16'h0e01, 16'h0e00));

    cyc(3);
    chk(iss_valid == 0 && tag_err == 0 && cmd_addr == 0, "R1 reset state",
        {iss_valid, tag_err, cmd_addr}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(iss_valid == 0 && tag_err == 0 && cmd_addr == 0, "R1 after reset",
        {iss_valid, tag_err, cmd_addr}, 0);

    // R2: host-only traffic, tag bits play no part
    send_host(hc(4'h9, 16'h1111, 16'h2222, 16'h3333), 1);
    send_host(hc(4'hA, 16'h0000, 16'hffff, 16'h0001), 1);
    send_host(hc(4'hB, 16'h8000, 16'h0001, 16'h7fff), 1);
    // R9: host jump discarded
    send_host(hc(4'hF, 16'h0, 16'h1, 16'd77), 0);
    cyc(3);
    chk(n_host == 3, "R9 host jump not issued", n_host, 3);
    chk(cmd_addr == 0, "R9 host jump leaves pc", cmd_addr, 0);

    // R3: host burst while a local instruction is ready
    for (int i = 0; i < 6; i++) begin
      logic [HW-1:0] c;
      @(negedge clk);
      if (i == 0) local_en = 1;
      c = hc(4'h8, 16'(i), 16'(i * 3), 16'(i * 7));
      hq_valid = 1; hq_cmd = c;
      host_q.push_back(c);
    end
    @(negedge clk);
    hq_valid = 0;
    #1;
    chk(n_local == 0, "R3 no local issue during host burst", n_local, 0);
    chk(n_host == 9, "R3 host burst issued", n_host, 9);

    // R4/R7: local run up to the stalled instruction at 10
    wait_addr(8'd10, "R7 taken jump to 10");
    cyc(3);
    chk(n_local == 2, "R4 local issues before stall", n_local, 2);
    hb = n_host;
    send_host(hc(4'h7, 16'h0707, 16'h0606, 16'h0505), 1);
    cyc(2);
    chk(n_host == hb + 1, "R10 host issued during stall", n_host, hb + 1);
    chk(n_local == 2, "R5 pending instruction held", n_local, 2);
    chk(cmd_addr == 10, "R5 pc held during stall", cmd_addr, 10);
    send_data(2'd1, 16'h1234);

    wait_addr(8'd13, "R7 fall-through to 12 then 13");
    cyc(3);
    chk(n_local == 4, "R7 fall-through issued op4", n_local, 4);
    send_data(2'd1, 16'h0001);
    cyc(3);
    chk(cmd_addr == 13, "R8 jump waits for target", cmd_addr, 13);
    send_data(2'd0, 16'd30);
    wait_addr(8'd30, "R8 jump after late direction and target");
    cyc(3);
    chk(n_local == 4, "R5 two pending operands hold op5", n_local, 4);
    send_data(2'd2, 16'h05b2);
    send_data(2'd1, 16'h05b1);
    wait_addr(8'd32, "R4 advance to 32");
    cyc(3);
    chk(n_local == 6, "R5 out-of-order fill issued", n_local, 6);
    chk(tag_err == 0, "R5 valid fills raise no error", tag_err, 0);
    send_data(2'd3, 16'h00aa);
    cyc(1);
    chk(tag_err == 1, "R6 tag 3 sets error", tag_err, 1);
    cyc(2);
    chk(tag_err == 1, "R6 error sticky", tag_err, 1);

    // phase 2: reset, slot-already-valid drop, wrap
    @(negedge clk);
    rst_n = 0; local_en = 0;
    cyc(2);
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[0]   = mk(4'hF, 3'b101, 16'h0, 16'h0, 16'd255);
    mem[255] = mk(4'h7, 3'b111, 16'h0077, 16'h0076, 16'h0075);
    chk(tag_err == 0 && iss_valid == 0 && cmd_addr == 0, "R1 reset clears state",
        {iss_valid, tag_err, cmd_addr}, 0);
    hb = n_local;
    local_q.push_back(hc(4'h7, 16'h0077, 16'h0076, 16'h0075));
    @(negedge clk);
    rst_n = 1; local_en = 1;
    cyc(3);
    send_data(2'd0, 16'd5);
    cyc(1);
    chk(tag_err == 1, "R6 fill of valid slot sets error", tag_err, 1);
    send_data(2'd1, 16'h0001);
    wait_addr(8'd255, "R6 dropped word left target at 255");
    wait_addr(8'd0, "R11 pc wraps to 0");
    cyc(3);
    chk(n_local == hb + 1, "R11 op at 255 issued once", n_local, hb + 1);
    chk(cmd_addr == 0, "R11 pc stays at 0 waiting", cmd_addr, 0);

    cyc(2);
    chk(host_q.size() == 0, "R2 all host commands issued", host_q.size(), 0);
    chk(local_q.size() == 0, "R4 all local instructions issued", local_q.size(), 0);

    $display("  Result: errors=%0d of %0d checks", errors + m_errors, checks + m_checks);
    $finish;
  end
endmodule